// File: doc/BRIEF.md
# Power-Management Bit-Write Sequencer

This block runs, in hardware, the transaction that writes a single control bit inside a power-management microcontroller. The microcontroller is reached through two byte-wide I/O ports. One is a data port. The other is a control/status port whose bit 0 reads back as a busy flag. A host pulses `start_i` with a register index, a bit value and a bit position. The sequencer then issues the whole port conversation by itself and reports the result on a one-cycle `done_o` or `err_o` pulse.

The conversation has two phases: a command byte, then a data byte. The command phase begins by telling the microcontroller that a command follows. The sequencer waits for busy to clear, places the command byte, flags it available and waits for busy to set. The data phase warns that data follows, waits for busy to clear, places the data byte, flags it available and waits for busy to set. Every wait polls the status port once per cycle. A wait that never sees the expected state ends the transaction with an error.

Typical targets are the serial-line supply (index 1, position 6) and two other supplies (index 0, positions 4 and 1). For these, a bit value of 0 switches power on and 1 switches it off.

Top module: `pmu_bitwr_seq`

## Requirements
- R1: While reset is held, and whenever `busy_o` is low, `busy_o`, `done_o` and `err_o` are low and neither `io_wr_o` nor `io_rd_o` is asserted.
- R2: In the cycle after an accepted `start_i`, `busy_o` is high and the block writes 0x02 to the status port (default address 0x199).
- R3: After the first wait ends, the block writes the command byte {4'h2, index} to the data port (default address 0x198). In the next cycle it writes 0x01 to the status port.
- R4: The port accesses run in this fixed order, one access per cycle: status write 0x02, wait for busy clear, command byte, status write 0x01, wait for busy set, status write 0x01, wait for busy clear, data byte, status write 0x01, wait for busy set. Each wait reads the status port every cycle. Only bit 0 of the read data is used, where 1 means busy.
- R5: The data byte has bits 7:4 at zero, bit 3 equal to the bit value and bits 2:0 equal to the position.
- R6: The block never reads and writes the port in the same cycle.
- R7: On success, `done_o` is high for exactly one cycle. That is the cycle after the final poll that sees busy set. `busy_o` is low in that cycle.
- R8: If a wait sees the wrong busy state on POLL_LIMIT+1 consecutive polls (default 1001), `err_o` is high for exactly one cycle, the cycle after the last of those polls. No further port access follows. A wait that sees exactly POLL_LIMIT wrong polls and then the right state continues.
- R9: The poll count restarts at every wait. A transaction in which each of the four waits sees POLL_LIMIT wrong polls before the right state completes with `done_o`.
- R10: `start_i` is ignored while `busy_o` is high, including in the cycle of the final poll. The operands are captured when the start is accepted. A `start_i` in the cycle where `done_o` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a bit-write transaction |
| index_i | input | 4 | Target register index |
| bit_i | input | 1 | Bit value to write |
| pos_i | input | 3 | Bit position within the register |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle timeout pulse |
| io_addr_o | output | ADDR_W (16) | Port address of the current access |
| io_wr_o | output | 1 | Port write strobe |
| io_rd_o | output | 1 | Port read strobe |
| io_wdata_o | output | 8 | Port write data |
| io_rdata_i | input | 8 | Port read data, bit 0 is the busy flag |

## Verification
Two events can meet in one cycle: a new `start_i`, and the end of the running transaction. The bench provokes this at both edges of the end. It raises `start_i` in the very cycle of the final busy-set poll, which must be ignored. It also raises `start_i` in the cycle where `done_o` is high, which must start a fresh transaction. The ignored case is judged by the port trace of the ending transaction and by a quiet bus and low `busy_o` in the cycles after `done_o`. The accepted case is judged by a correct status write of 0x02 in the following cycle and a full trace carrying the new operands.

// File: rtl/pmu_bitwr_pkg.sv
package pmu_bitwr_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 4;
  localparam int POS_W  = 3;
  localparam int BUSY_BIT = 0;

  localparam logic [3:0]        OP_WRBIT    = 4'h2;
  localparam logic [BYTE_W-1:0] CSR_CMD_NXT = 8'h02;
  localparam logic [BYTE_W-1:0] CSR_AVAIL   = 8'h01;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPEN,   // announce command
    ST_RDY1,   // wait busy clear
    ST_CMD,    // command byte
    ST_AVL1,
    ST_ACK1,   // wait busy set
    ST_NEXT,   // announce data
    ST_RDY2,
    ST_DATA,   // data byte
    ST_AVL2,
    ST_ACK2
  } step_e;

  function automatic logic is_poll(step_e s);
    return (s == ST_RDY1) || (s == ST_ACK1) || (s == ST_RDY2) || (s == ST_ACK2);
  endfunction

  function automatic logic poll_wants_set(step_e s);
    return (s == ST_ACK1) || (s == ST_ACK2);
  endfunction

  function automatic logic [BYTE_W-1:0] cmd_byte(logic [IDX_W-1:0] idx);
    return {OP_WRBIT, idx};
  endfunction

  function automatic logic [BYTE_W-1:0] data_byte(logic b, logic [POS_W-1:0] pos);
    return {{(BYTE_W-POS_W-1){1'b0}}, b, pos};
  endfunction
endpackage

// File: rtl/pmu_poll_timer.sv
module pmu_poll_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CNT_W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/pmu_port_mux.sv
module pmu_port_mux
  import pmu_bitwr_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h0198,
  parameter logic [ADDR_W-1:0] CSR_ADDR  = 16'h0199
) (
  input  step_e              step_i,
  input  logic [BYTE_W-1:0]  cmd_i,
  input  logic [BYTE_W-1:0]  dat_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               wr_o,
  output logic               rd_o,
  output logic [BYTE_W-1:0]  wdata_o
);
  always_comb begin
    addr_o  = '0;
    wr_o    = 1'b0;
    rd_o    = 1'b0;
    wdata_o = '0;
    unique case (step_i)
      ST_OPEN: begin
        addr_o = CSR_ADDR; wr_o = 1'b1; wdata_o = CSR_CMD_NXT;
      end
      ST_CMD: begin
        addr_o = DATA_ADDR; wr_o = 1'b1; wdata_o = cmd_i;
      end
      ST_DATA: begin
        addr_o = DATA_ADDR; wr_o = 1'b1; wdata_o = dat_i;
      end
      ST_AVL1, ST_NEXT, ST_AVL2: begin
        addr_o = CSR_ADDR; wr_o = 1'b1; wdata_o = CSR_AVAIL;
      end
      ST_RDY1, ST_ACK1, ST_RDY2, ST_ACK2: begin
        addr_o = CSR_ADDR; rd_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pmu_bitwr_seq.sv
module pmu_bitwr_seq
  import pmu_bitwr_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h0198,
  parameter logic [ADDR_W-1:0] CSR_ADDR   = 16'h0199,
  parameter int                POLL_LIMIT = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        index_i,
  input  logic              bit_i,
  input  logic [2:0]        pos_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic              io_wr_o,
  output logic              io_rd_o,
  output logic [7:0]        io_wdata_o,
  input  logic [7:0]        io_rdata_i
);
  step_e             state_q, state_d;
  logic [BYTE_W-1:0] cmd_q, dat_q;
  logic              done_q, done_d, err_q, err_d;
  logic              accept, in_poll, hit, expired;

  assign in_poll = is_poll(state_q);
  assign hit     = (io_rdata_i[BUSY_BIT] == poll_wants_set(state_q));

  pmu_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!in_poll),
    .tick_i    (in_poll && !hit),
    .expired_o (expired)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    accept  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin state_d = ST_OPEN; accept = 1'b1; end
      ST_OPEN: state_d = ST_RDY1;
      ST_RDY1: if (hit) state_d = ST_CMD;
      ST_CMD:  state_d = ST_AVL1;
      ST_AVL1: state_d = ST_ACK1;
      ST_ACK1: if (hit) state_d = ST_NEXT;
      ST_NEXT: state_d = ST_RDY2;
      ST_RDY2: if (hit) state_d = ST_DATA;
      ST_DATA: state_d = ST_AVL2;
      ST_AVL2: state_d = ST_ACK2;
      ST_ACK2: if (hit) begin state_d = ST_IDLE; done_d = 1'b1; end
      default: state_d = ST_IDLE;
    endcase
    // wrong state on the poll after the limit: abort
    if (in_poll && !hit && expired) begin
      state_d = ST_IDLE;
      done_d  = 1'b0;
      err_d   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      dat_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (accept) begin
        cmd_q <= cmd_byte(index_i);
        dat_q <= data_byte(bit_i, pos_i);
      end
    end
  end

  pmu_port_mux #(
    .ADDR_W    (ADDR_W),
    .DATA_ADDR (DATA_ADDR),
    .CSR_ADDR  (CSR_ADDR)
  ) u_mux (
    .step_i  (state_q),
    .cmd_i   (cmd_q),
    .dat_i   (dat_q),
    .addr_o  (io_addr_o),
    .wr_o    (io_wr_o),
    .rd_o    (io_rd_o),
    .wdata_o (io_wdata_o)
  );

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/pmu_bitwr_chk.sv
module pmu_bitwr_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h0198,
  parameter logic [ADDR_W-1:0] CSR_ADDR  = 16'h0199
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [ADDR_W-1:0] io_addr_o,
  input logic              io_wr_o,
  input logic              io_rd_o,
  input logic [7:0]        io_wdata_o
);
  p_excl_access_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_o |-> !io_rd_o);

  p_quiet_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!io_wr_o && !io_rd_o));

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (io_wr_o && io_addr_o == CSR_ADDR && io_wdata_o == 8'h02));

  p_cmd_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_o && io_addr_o == DATA_ADDR) |=> (io_wr_o && io_addr_o == CSR_ADDR && io_wdata_o == 8'h01));

  p_done_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !err_o && $past(io_rd_o)));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && $past(io_rd_o)));

  p_err_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  p_hold_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o || err_o));
endmodule

bind pmu_bitwr_seq pmu_bitwr_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_ADDR (DATA_ADDR),
  .CSR_ADDR  (CSR_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .io_addr_o  (io_addr_o),
  .io_wr_o    (io_wr_o),
  .io_rd_o    (io_rd_o),
  .io_wdata_o (io_wdata_o)
);

// File: tb/tb_pmu_bitwr_seq.sv
module tb_pmu_bitwr_seq;
  localparam int          LIMIT = 1000;
  localparam logic [15:0] DAT   = 16'h0198;
  localparam logic [15:0] CSR   = 16'h0199;

  logic        clk, rst_n, start_i, bit_i;
  logic [3:0]  index_i;
  logic [2:0]  pos_i;
  logic        busy_o, done_o, err_o, io_wr_o, io_rd_o;
  logic [15:0] io_addr_o;
  logic [7:0]  io_wdata_o, io_rdata_i;

  pmu_bitwr_seq #(.ADDR_W(16), .DATA_ADDR(DAT), .CSR_ADDR(CSR), .POLL_LIMIT(LIMIT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .index_i(index_i), .bit_i(bit_i),
    .pos_i(pos_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .io_addr_o(io_addr_o),
    .io_wr_o(io_wr_o), .io_rd_o(io_rd_o), .io_wdata_o(io_wdata_o), .io_rdata_i(io_rdata_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int d[4];
  logic [3:0] t_idx;
  logic       t_bit;
  logic [2:0] t_pos;
  int k = 0, w = 0, p = 0, end_k = 0;
  int mis_r2 = 0, mis_r3 = 0, mis_r4 = 0, mis_r5 = 0, r6_bad = 0;
  bit tx_end = 0, saw_done = 0, saw_err = 0, busy_end = 0, last_poll = 0;

  function automatic int seg_wait(int s);
    case (s)
      1: return 0;
      4: return 1;
      6: return 2;
      9: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic int seg_len(int s);
    int wi = seg_wait(s);
    if (wi < 0) return 1;
    return (d[wi] > LIMIT) ? LIMIT + 1 : d[wi] + 1;
  endfunction

  // expected op {wr, rd, addr, data}; cat = requirement number of the segment
  function automatic bit exp_op(input int kk, output logic [25:0] op, output int cat);
    int r = kk;
    op = '0; cat = 4;
    for (int s = 0; s < 10; s++) begin
      if (r < seg_len(s)) begin
        case (s)
          0: begin op = {2'b10, CSR, 8'h02}; cat = 2; end
          2: begin op = {2'b10, DAT, {4'h2, t_idx}}; cat = 3; end
          3: begin op = {2'b10, CSR, 8'h01}; cat = 3; end
          5, 8: begin op = {2'b10, CSR, 8'h01}; cat = 4; end
          7: begin op = {2'b10, DAT, {4'h0, t_bit, t_pos}}; cat = 5; end
          default: begin op = {2'b01, CSR, 8'h00}; cat = 4; end
        endcase
        return 1'b1;
      end
      r -= seg_len(s);
      if (seg_wait(s) >= 0 && d[seg_wait(s)] > LIMIT) return 1'b0;
    end
    return 1'b0;
  endfunction

  function automatic int exp_total();
    int t = 0;
    for (int s = 0; s < 10; s++) begin
      t += seg_len(s);
      if (seg_wait(s) >= 0 && d[seg_wait(s)] > LIMIT) return t;
    end
    return t;
  endfunction

  function automatic bit exp_fail();
    for (int i = 0; i < 4; i++) if (d[i] > LIMIT) return 1'b1;
    return 1'b0;
  endfunction

  // bus monitor and microcontroller model
  always @(negedge clk) begin
    logic [25:0] eop, aop;
    int cat;
    bit want;
    last_poll = 1'b0;
    io_rdata_i = 8'($urandom);
    if (rst_n) begin
      if (io_wr_o && io_rd_o) r6_bad++;
      if (io_wr_o || io_rd_o) begin
        aop = {io_wr_o, io_rd_o, io_addr_o, io_rd_o ? 8'h00 : io_wdata_o};
        if (!exp_op(k, eop, cat)) mis_r4++;
        else if (eop != aop) begin
          case (cat)
            2: mis_r2++;
            3: mis_r3++;
            5: mis_r5++;
            default: mis_r4++;
          endcase
        end
        if (io_rd_o && w < 4) begin
          want = (w == 1 || w == 3);
          if (p < d[w]) begin
            io_rdata_i[0] = ~want;
            p++;
          end else begin
            io_rdata_i[0] = want;
            if (w == 3) last_poll = 1'b1;
            w++;
            p = 0;
          end
        end
        k++;
      end
      if ((done_o || err_o) && !tx_end) begin
        tx_end = 1'b1; end_k = k;
        saw_done = done_o; saw_err = err_o; busy_end = busy_o;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at #1 after a negedge
  task automatic launch(int d0, int d1, int d2, int d3, logic [3:0] idx, logic b, logic [2:0] pos);
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    t_idx = idx; t_bit = b; t_pos = pos;
    k = 0; w = 0; p = 0; end_k = 0;
    mis_r2 = 0; mis_r3 = 0; mis_r4 = 0; mis_r5 = 0;
    tx_end = 0; saw_done = 0; saw_err = 0; busy_end = 0;
    start_i = 1'b1; index_i = idx; bit_i = b; pos_i = pos;
    @(negedge clk); #1;
    start_i = 1'b0;
    index_i = 4'($urandom); bit_i = 1'($urandom); pos_i = 3'($urandom);
  endtask

  task automatic finish_tx(int poke_at, bit poke_last, bit chain);
    int n = 0;
    bit f = exp_fail();
    while (!tx_end) begin
      start_i = (n == poke_at) || (poke_last && last_poll);  // R10: must be ignored
      index_i = ~t_idx; bit_i = ~t_bit; pos_i = ~t_pos;
      @(negedge clk); #1;
      n++;
      if (n > 6000) break;
    end
    start_i = 1'b0;
    if (f) chk(saw_err && !saw_done, "R8", "err outcome", int'(saw_err), 1);
    else   chk(saw_done && !saw_err, "R7", "done outcome", int'(saw_done), 1);
    chk(end_k == exp_total(), f ? "R8" : "R7", "accesses before end", end_k, exp_total());
    chk(!busy_end, "R7", "busy at end", int'(busy_end), 0);
    chk(mis_r2 == 0, "R2", "open write mismatches", mis_r2, 0);
    chk(mis_r3 == 0, "R3", "command byte mismatches", mis_r3, 0);
    chk(mis_r4 == 0, "R4", "sequence mismatches", mis_r4, 0);
    chk(mis_r5 == 0, "R5", "data byte mismatches", mis_r5, 0);
    if (!chain) begin
      @(negedge clk); #1;
      chk(!done_o && !err_o, f ? "R8" : "R7", "pulse width", int'(done_o | err_o), 0);
      repeat (4) @(negedge clk);
      #1;
      chk(k == end_k && !busy_o, "R10", "no access after end", k, end_k);
    end
  endtask

  task automatic run_tx(int d0, int d1, int d2, int d3, logic [3:0] idx, logic b,
                        logic [2:0] pos, int poke_at, bit poke_last, bit chain);
    launch(d0, d1, d2, d3, idx, b, pos);
    finish_tx(poke_at, poke_last, chain);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0; start_i = 1'b0; index_i = '0; bit_i = 1'b0; pos_i = '0;
    io_rdata_i = '0;
    d[0] = 0; d[1] = 0; d[2] = 0; d[3] = 0;
    t_idx = '0; t_bit = 1'b0; t_pos = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy_o && !done_o && !err_o && !io_wr_o && !io_rd_o, "R1", "reset outputs",
        int'({busy_o, done_o, err_o, io_wr_o, io_rd_o}), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy_o && !io_wr_o && !io_rd_o, "R1", "idle after reset",
        int'({busy_o, io_wr_o, io_rd_o}), 0);

    // directed: typical targets, no waiting
    run_tx(0, 0, 0, 0, 4'd1, 1'b0, 3'd6, -1, 1'b0, 1'b0);
    run_tx(0, 0, 0, 0, 4'd0, 1'b1, 3'd4, -1, 1'b0, 1'b0);
    // R10: start pulses mid-run and in the final poll cycle
    run_tx(1, 2, 0, 3, 4'd0, 1'b0, 3'd1, 2, 1'b1, 1'b0);
    // R8 boundary: exactly LIMIT wrong polls still succeeds; R9: in every wait
    run_tx(LIMIT, LIMIT, LIMIT, LIMIT, 4'hA, 1'b1, 3'd7, -1, 1'b0, 1'b0);
    // R8: timeouts in different waits
    run_tx(LIMIT + 1, 0, 0, 0, 4'h3, 1'b1, 3'd2, -1, 1'b0, 1'b0);
    run_tx(0, LIMIT + 5, 0, 0, 4'h5, 1'b0, 3'd3, -1, 1'b0, 1'b0);
    run_tx(2, 1, 2, LIMIT + 1, 4'hF, 1'b1, 3'd0, -1, 1'b0, 1'b0);
    // R10: start in the done cycle is accepted
    run_tx(0, 1, 0, 1, 4'h6, 1'b1, 3'd5, -1, 1'b1, 1'b1);
    run_tx(1, 0, 1, 0, 4'h9, 1'b0, 3'd2, -1, 1'b0, 1'b0);

    for (int i = 0; i < 25; i++) begin
      int pk = ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, 3)) : -1;
      run_tx(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
             int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
             4'($urandom), 1'($urandom), 3'($urandom), pk, 1'($urandom), 1'b0);
    end

    chk(r6_bad == 0, "R6", "read and write in one cycle", r6_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule